// File: doc/BRIEF.md
# I2C Status Flag Controller

This block holds the event status flags of an I2C peripheral. A separate protocol engine and bus monitor deliver single-cycle event strobes. The strobes cover a detected start or stop, a generated start, a sent 10-bit address header, an address match, a completed acknowledge pulse, lost arbitration and a finished DMA transfer. The block turns these strobes into sticky flags. It raises an interrupt request for pending events and asks the engine to stretch SCL while software still owes an action.

Software sees the flags through a small register bus with two registers, selected by `regSel`. The status register (select 0) is read-only. The data register (select 1) latches a byte on write and returns the received byte on read. Several flags are acknowledged by a two-step sequence: a status read, followed directly by the right kind of data register access. A one-bit sequence latch tracks that pairing. Any other access in between cancels the sequence.

Top module: `i2c_status_flags`

## Requirements
- R1: After reset the status register reads 0x00, and `irq` and `sclHold` are 0.
- R2: The status bit layout is: bit 7 is the event summary (the OR of bits 6, 3, 2 and 0); bit 6 is the 10-bit header flag; bit 5 is transmit direction; bit 4 is bus busy; bit 3 is byte finished; bit 2 is address matched; bit 1 is master mode; bit 0 is start generated. A read with `regSel`=0 returns this value on `rdData` in the same cycle.
- R3: The start-generated flag sets on `evStartGen`. It clears only on a data register write that directly follows a status read. A data write without that preceding read leaves it set.
- R4: The 10-bit header flag sets on `evHeaderSent`. It clears on a status read followed by a data write, or on `evStopDet`.
- R5: `evAckDone` sets the byte-finished flag when `xferTx`=1. When `xferTx`=0 it sets the flag only if `ackEn`=1. The transmit direction flag takes the value of `xferTx` when byte-finished sets.
- R6: Byte-finished clears on a status read followed by a data read when transmit direction is 0, or followed by a data write when it is 1. An access of the other kind does not clear it. `evDmaDone` clears it at any time. Transmit direction clears whenever byte-finished clears.
- R7: The master mode flag sets on `evStartGen`. Master mode and transmit direction both clear on `evStopDet` or `evArbLost`.
- R8: Bus busy sets on `evStartDet` and clears on `evStopDet`, also while `enable`=0.
- R9: The address matched flag sets on `evAddrMatch`. A status read alone clears it. That read still returns the flag as 1.
- R10: A status write, or a second data access, between the status read and the data access cancels the acknowledge sequence.
- R11: `sclHold` is 1 while start-generated, byte-finished or address matched is set. `irq` equals the event summary bit when `irqEn`=1 and is 0 when `irqEn`=0.
- R12: While `enable`=0 every flag except bus busy reads 0, and the events that would set those flags are ignored.
- R13: A data register write stores `wrData` on `txData`. A data register read returns `rxByte` on `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Peripheral enable |
| irqEn | input | 1 | Interrupt enable |
| ackEn | input | 1 | Acknowledge enable for received bytes |
| xferTx | input | 1 | Direction of the byte whose acknowledge completed (1 = transmitted) |
| evStartDet | input | 1 | Start condition seen on the bus |
| evStopDet | input | 1 | Stop condition seen on the bus |
| evStartGen | input | 1 | Start condition generated by this master |
| evHeaderSent | input | 1 | First header byte of a 10-bit address sent |
| evAddrMatch | input | 1 | Received address matched own or general call address |
| evAckDone | input | 1 | Acknowledge clock pulse completed |
| evArbLost | input | 1 | Arbitration lost |
| evDmaDone | input | 1 | DMA transfer complete |
| regSel | input | 1 | Register select: 0 status, 1 data |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| wrData | input | DATA_W | Write data |
| rxByte | input | DATA_W | Received byte from the engine |
| rdData | output | DATA_W | Read data |
| txData | output | DATA_W | Byte to transmit |
| status | output | 8 | Live status flags |
| irq | output | 1 | Interrupt request |
| sclHold | output | 1 | Request to hold SCL low |

## Verification
The assertions take several things for granted about the inputs. Each event strobe lasts one cycle. `evStartDet` and `evStopDet` never fire together. No more than one register access happens per cycle, so `regRd` and `regWr` are never high together. The stimulus keeps to these limits by applying exactly one event or one register access per operation and deasserting it before the next one. Sequence cancelling is exercised only through legal single accesses: a status write, or a data access without a preceding status read.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int BIT_EVF = 7;
  localparam int BIT_A10 = 6;
  localparam int BIT_TRA = 5;
  localparam int BIT_BSY = 4;
  localparam int BIT_BTF = 3;
  localparam int BIT_ADS = 2;
  localparam int BIT_MST = 1;
  localparam int BIT_SB  = 0;

  typedef struct packed {
    logic clrSb;
    logic clrHdr;
    logic clrBtf;
    logic clrAdsl;
    logic dataWr;
  } ctrlStrb_t;
endpackage

// File: rtl/i2c_stat_ctrl.sv
module i2c_stat_ctrl
  import i2c_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      regSel,
  input  logic      regRd,
  input  logic      regWr,
  input  logic      traNow,
  output ctrlStrb_t strb
);
  logic armed;
  logic statusRd;
  logic dataRdSeq;
  logic dataWrSeq;

  assign statusRd  = regRd & ~regSel;
  assign dataRdSeq = armed & regRd & regSel;
  assign dataWrSeq = armed & regWr & regSel;

  // one-shot sequence latch: armed by a status read, dropped by any other access
  always_ff @(posedge clk) begin
    if (!rstN)                 armed <= 1'b0;
    else if (!enable)          armed <= 1'b0;
    else if (statusRd)         armed <= 1'b1;
    else if (regRd || regWr)   armed <= 1'b0;
  end

  always_comb begin
    strb.clrSb   = dataWrSeq;
    strb.clrHdr  = dataWrSeq;
    strb.clrBtf  = traNow ? dataWrSeq : dataRdSeq;
    strb.clrAdsl = statusRd;
    strb.dataWr  = regWr & regSel;
  end

  // R10: a data access consumes the latch
  p_seq_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    (armed && regSel && (regRd || regWr)) |=> !armed);
endmodule

// File: rtl/i2c_stat_dp.sv
module i2c_stat_dp
  import i2c_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              ackEn,
  input  logic              xferTx,
  input  logic              evStartDet,
  input  logic              evStopDet,
  input  logic              evStartGen,
  input  logic              evHeaderSent,
  input  logic              evAddrMatch,
  input  logic              evAckDone,
  input  logic              evArbLost,
  input  logic              evDmaDone,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [STAT_W-1:0] statusVec,
  output logic [DATA_W-1:0] txData
);
  logic sb, hdr, tra, busy, btf, adsl, mst;
  logic btfSet, btfClr;

  assign btfSet = evAckDone & (xferTx | ackEn);
  assign btfClr = strb.clrBtf | evDmaDone;

  // bus busy follows the monitor regardless of enable
  always_ff @(posedge clk) begin
    if (!rstN)           busy <= 1'b0;
    else if (evStartDet) busy <= 1'b1;
    else if (evStopDet)  busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      sb <= 1'b0; hdr <= 1'b0; tra <= 1'b0;
      btf <= 1'b0; adsl <= 1'b0; mst <= 1'b0;
    end else begin
      if (evStartGen)       sb <= 1'b1;
      else if (strb.clrSb)  sb <= 1'b0;

      if (evHeaderSent)                   hdr <= 1'b1;
      else if (strb.clrHdr || evStopDet)  hdr <= 1'b0;

      if (btfSet)       btf <= 1'b1;
      else if (btfClr)  btf <= 1'b0;

      if (btfSet)                                  tra <= xferTx;
      else if (btfClr || evStopDet || evArbLost)   tra <= 1'b0;

      if (evAddrMatch)        adsl <= 1'b1;
      else if (strb.clrAdsl)  adsl <= 1'b0;

      if (evStartGen)                   mst <= 1'b1;
      else if (evStopDet || evArbLost)  mst <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            txData <= '0;
    else if (strb.dataWr) txData <= wrData;
  end

  always_comb begin
    statusVec          = '0;
    statusVec[BIT_A10] = hdr;
    statusVec[BIT_TRA] = tra;
    statusVec[BIT_BSY] = busy;
    statusVec[BIT_BTF] = btf;
    statusVec[BIT_ADS] = adsl;
    statusVec[BIT_MST] = mst;
    statusVec[BIT_SB]  = sb;
    statusVec[BIT_EVF] = hdr | btf | adsl | sb;
  end

  // R12: disable wipes everything but busy
  p_disable_clear_r12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ((statusVec & 8'hEF) == 8'h00));
  // R3: start flag survives without the acknowledge sequence
  p_sb_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sb && enable && !strb.clrSb) |=> sb);
  // R6: direction never outlives byte-finished
  p_tra_btf_r6: assert property (@(posedge clk) disable iff (!rstN)
    tra |-> btf);
  // R8: stop drops busy
  p_busy_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evStopDet && !evStartDet) |=> !busy);
  // R9: status read clears address match
  p_adsl_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && strb.clrAdsl && !evAddrMatch) |=> !adsl);
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
  import i2c_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              irqEn,
  input  logic              ackEn,
  input  logic              xferTx,
  input  logic              evStartDet,
  input  logic              evStopDet,
  input  logic              evStartGen,
  input  logic              evHeaderSent,
  input  logic              evAddrMatch,
  input  logic              evAckDone,
  input  logic              evArbLost,
  input  logic              evDmaDone,
  input  logic              regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] txData,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              sclHold
);
  ctrlStrb_t strb;
  logic [STAT_W-1:0] statusVec;

  i2c_stat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .regSel(regSel), .regRd(regRd), .regWr(regWr),
    .traNow(statusVec[BIT_TRA]), .strb(strb)
  );

  i2c_stat_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .ackEn(ackEn), .xferTx(xferTx),
    .evStartDet(evStartDet), .evStopDet(evStopDet), .evStartGen(evStartGen),
    .evHeaderSent(evHeaderSent), .evAddrMatch(evAddrMatch), .evAckDone(evAckDone),
    .evArbLost(evArbLost), .evDmaDone(evDmaDone), .strb(strb), .wrData(wrData),
    .statusVec(statusVec), .txData(txData)
  );

  assign status  = statusVec;
  assign rdData  = regSel ? rxByte : DATA_W'(statusVec);
  assign irq     = irqEn & statusVec[BIT_EVF];
  assign sclHold = statusVec[BIT_SB] | statusVec[BIT_BTF] | statusVec[BIT_ADS];

  // R11: no stretch request without a pending event
  p_hold_evf_r11: assert property (@(posedge clk) disable iff (!rstN)
    sclHold |-> status[BIT_EVF]);
endmodule

// File: tb/i2c_status_flags_tb.sv
`timescale 1ns/1ps
module i2c_status_flags_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1, irqEn = 1'b1, ackEn = 1'b1, xferTx = 1'b0;
  logic evStartDet = 0, evStopDet = 0, evStartGen = 0, evHeaderSent = 0;
  logic evAddrMatch = 0, evAckDone = 0, evArbLost = 0, evDmaDone = 0;
  logic regSel = 0, regRd = 0, regWr = 0;
  logic [7:0] wrData = 8'h00, rxByte = 8'h00;
  logic [7:0] rdData, txData, status;
  logic irq, sclHold;
  int nChecks = 0, nFail = 0;

  always #2.5 clk = ~clk;

  i2c_status_flags u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .irqEn(irqEn), .ackEn(ackEn),
    .xferTx(xferTx), .evStartDet(evStartDet), .evStopDet(evStopDet),
    .evStartGen(evStartGen), .evHeaderSent(evHeaderSent), .evAddrMatch(evAddrMatch),
    .evAckDone(evAckDone), .evArbLost(evArbLost), .evDmaDone(evDmaDone),
    .regSel(regSel), .regRd(regRd), .regWr(regWr), .wrData(wrData), .rxByte(rxByte),
    .rdData(rdData), .txData(txData), .status(status), .irq(irq), .sclHold(sclHold)
  );

  // op codes: 0 startDet 1 stopDet 2 startGen 3 header 4 addrMatch 5 ackTx
  // 6 ackRx 7 arbLost 8 dma 9 statusRd 10 dataRd 11 dataWr 12 statusWr
  localparam int NVEC = 29;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd0, 8'h10}, {4'd2, 8'h93}, {4'd9, 8'h93}, {4'd11, 8'h12},
    {4'd5, 8'hBA}, {4'd10, 8'hBA}, {4'd9, 8'hBA}, {4'd10, 8'hBA},
    {4'd11, 8'hBA}, {4'd9, 8'hBA}, {4'd11, 8'h12}, {4'd6, 8'h9A},
    {4'd9, 8'h9A}, {4'd12, 8'h9A}, {4'd10, 8'h9A}, {4'd9, 8'h9A},
    {4'd10, 8'h12}, {4'd3, 8'hD2}, {4'd1, 8'h00}, {4'd4, 8'h84},
    {4'd9, 8'h00}, {4'd5, 8'hA8}, {4'd8, 8'h00}, {4'd2, 8'h83},
    {4'd5, 8'hAB}, {4'd7, 8'h89}, {4'd9, 8'h89}, {4'd11, 8'h88},
    {4'd8, 8'h00}
  };

  function automatic string reqOf(input int op);
    case (op)
      0, 1:    return "R8";
      2:       return "R3";
      3:       return "R4";
      4:       return "R9";
      5, 6:    return "R5";
      7:       return "R7";
      8:       return "R6";
      12:      return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic setOp(input int op, input logic v);
    case (op)
      0:  evStartDet = v;
      1:  evStopDet = v;
      2:  evStartGen = v;
      3:  evHeaderSent = v;
      4:  evAddrMatch = v;
      5:  begin evAckDone = v; xferTx = v; end
      6:  begin evAckDone = v; xferTx = 1'b0; end
      7:  evArbLost = v;
      8:  evDmaDone = v;
      9:  begin regSel = 1'b0; regRd = v; end
      10: begin regSel = 1'b1; regRd = v; end
      11: begin regSel = 1'b1; regWr = v; end
      12: begin regSel = 1'b0; regWr = v; end
      default: ;
    endcase
  endtask

  // drive at a falling edge, hold across one rising edge, release
  task automatic doOp(input int op);
    @(negedge clk);
    setOp(op, 1'b1);
    @(negedge clk);
    setOp(op, 1'b0);
  endtask

  initial begin
    #(5.0 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status", status, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 sclHold", {7'd0, sclHold}, 8'h00);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      int op;
      logic [7:0] exp;
      op = int'(VEC[i][11:8]);
      exp = VEC[i][7:0];
      doOp(op);
      check(reqOf(op), status, exp);
      check("R11 irq", {7'd0, irq}, {7'd0, exp[7]});
      check("R11 sclHold", {7'd0, sclHold}, {7'd0, exp[0] | exp[2] | exp[3]});
    end

    // R9 and R2: read returns matched flag, then it clears
    doOp(4);
    @(negedge clk);
    regSel = 1'b0; regRd = 1'b1;
    #1 check("R2 R9 rdData", rdData, 8'h84);
    @(negedge clk);
    regRd = 1'b0;
    check("R9 after read", status, 8'h00);

    // R5: received byte without ack enable sets nothing
    ackEn = 1'b0;
    doOp(6);
    check("R5 no ack", status, 8'h00);
    ackEn = 1'b1;

    // R11: interrupt gating
    irqEn = 1'b0;
    doOp(2);
    check("R11 irq gated", {7'd0, irq}, 8'h00);
    check("R11 hold", {7'd0, sclHold}, 8'h01);
    irqEn = 1'b1;
    #1 check("R11 irq on", {7'd0, irq}, 8'h01);

    // R12 and R8: disable clears and blocks, busy keeps tracking
    doOp(0);
    check("R8 busy", status, 8'h93);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R12 disable", status, 8'h10);
    doOp(2);
    check("R12 ignored", status, 8'h10);
    doOp(1);
    check("R8 disabled stop", status, 8'h00);
    enable = 1'b1;

    // R13: data register path
    wrData = 8'h5A;
    doOp(11);
    check("R13 txData", txData, 8'h5A);
    rxByte = 8'hC3;
    @(negedge clk);
    regSel = 1'b1; regRd = 1'b1;
    #1 check("R13 rdData", rdData, 8'hC3);
    @(negedge clk);
    regRd = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule